// File: doc/BRIEF.md
# Length-Prefixed Packet Delimiter

This block sits on a byte stream that carries asynchronous or control packets back to back and marks where each packet begins and ends. Every packet opens with a two-byte length field. The field gives the number of message bytes that follow it, and does not count its own two bytes. The block reads that field, counts down the remaining bytes, and flags the last byte. The next byte is then taken as the first byte of the next length field. How the stream is cut into pages has no effect on this: a packet may run over several pages, and one page may hold several packets.

Each byte passes through one register stage and leaves with three tags: a packet-start flag, a packet-end flag and its position inside the packet. The page-boundary flag travels with the byte unchanged. Both sides use valid/ready handshakes. A byte moves on a side when valid and ready are both high at a rising clock edge. The input is ready whenever the output register is empty or is being drained in the same cycle. An output beat that is not taken stays unchanged until it is taken. The sender may raise or drop valid at any cycle.

Top module: `pkt_len_delim`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid is 0 and in_ready is 1. The first byte accepted after reset is treated as the first byte of a length field, even if reset cut a packet short.
- R2: in_ready equals (!out_valid || out_ready). While out_valid is 1 and out_ready is 0, every output holds its value into the next cycle.
- R3: The first byte of every packet leaves with out_sop=1 and out_pos=0. No other byte has out_sop=1.
- R4: The length L is the first byte times 256 plus the second byte, so the most significant byte comes first. L excludes the two length bytes. out_eop is 1 only on the byte at out_pos = L+1.
- R5: When L=0, out_eop is 1 on the second length byte, and that packet has only two bytes.
- R6: The byte accepted right after an end-of-packet byte leaves with out_sop=1. This lets several packets share one page with no gap.
- R7: in_page_end has no effect on sop, eop or pos. A packet that runs over a page boundary keeps its count. out_page_end, out_data and the position tags belong to the same byte.
- R8: Within a packet, out_pos goes up by exactly one from each byte to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Block can accept the input byte |
| in_data | input | 8 | Input byte |
| in_page_end | input | 1 | Input byte is the last byte of a page |
| out_valid | output | 1 | Output beat is present |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 8 | Byte, passed through unchanged |
| out_page_end | output | 1 | Page-end flag of this byte |
| out_sop | output | 1 | Byte is the first of a packet |
| out_eop | output | 1 | Byte is the last of a packet |
| out_pos | output | 17 | Position of this byte within its packet, starting at 0 |

## Verification
The tests use a single short packet, then a zero-length packet followed directly by a one-byte packet, then a run of packets fed in five-byte pages. These show that the end is found from the header value and not from page edges, and that an empty packet and a packet back to back with it are both handled. A 300-byte packet with a nonzero high length byte shows whether the two length bytes are combined in the right order. It runs under output back-pressure and input gaps, to separate correct holding of a beat from lost or repeated bytes. Reset is also applied in the middle of a packet, to check that parsing starts again at a header.

// File: rtl/pkt_len_delim_pkg.sv
package pkt_len_delim_pkg;
  typedef enum logic [1:0] {
    PH_LEN_HI = 2'd0,
    PH_LEN_LO = 2'd1,
    PH_BODY   = 2'd2
  } pld_phase_e;
endpackage

// File: rtl/pld_len_tracker.sv
module pld_len_tracker
  import pkt_len_delim_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [7:0]       byte_in,
  output logic             is_sop,
  output logic             is_eop,
  output logic [CNT_W-1:0] pos
);
  localparam int HI_W = LEN_W - 8;

  pld_phase_e        phase_q;
  logic [HI_W-1:0]   len_hi_q;
  logic [LEN_W-1:0]  remain_q;
  logic [CNT_W-1:0]  pos_q;
  logic [LEN_W-1:0]  full_len;

  assign full_len = {len_hi_q, byte_in};
  assign is_sop   = (phase_q == PH_LEN_HI);
  assign pos      = pos_q;

  always_comb begin
    unique case (phase_q)
      PH_LEN_LO: is_eop = (full_len == '0);
      PH_BODY:   is_eop = (remain_q == LEN_W'(1));
      default:   is_eop = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_LEN_HI;
      len_hi_q <= '0;
      remain_q <= '0;
      pos_q    <= '0;
    end else if (step) begin
      unique case (phase_q)
        PH_LEN_HI: begin
          len_hi_q <= byte_in[HI_W-1:0];
          phase_q  <= PH_LEN_LO;
          pos_q    <= CNT_W'(1);
        end
        PH_LEN_LO: begin
          if (full_len == '0) begin
            phase_q <= PH_LEN_HI;
            pos_q   <= '0;
          end else begin
            remain_q <= full_len;
            phase_q  <= PH_BODY;
            pos_q    <= CNT_W'(2);
          end
        end
        default: begin
          if (remain_q == LEN_W'(1)) begin
            phase_q <= PH_LEN_HI;
            pos_q   <= '0;
          end else begin
            pos_q <= pos_q + CNT_W'(1);
          end
          remain_q <= remain_q - LEN_W'(1);
        end
      endcase
    end
  end

  // R4: the body phase never runs with nothing left to count
  a_r4_remain_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_BODY) |-> (remain_q != '0));

  // R6: an accepted end byte returns the parser to the header
  a_r6_eop_back_to_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    (step && is_eop) |=> (phase_q == PH_LEN_HI));
endmodule

// File: rtl/pld_out_slice.sv
module pld_out_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_payload,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_payload
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid   <= 1'b0;
      m_payload <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_payload <= s_payload;
    end
  end

  // R2: a beat that is held back keeps its content
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_payload)));
endmodule

// File: rtl/pkt_len_delim.sv
module pkt_len_delim #(
  parameter int LEN_W = 16,
  parameter int CNT_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_page_end,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_page_end,
  output logic             out_sop,
  output logic             out_eop,
  output logic [CNT_W-1:0] out_pos
);
  localparam int PW = 8 + 3 + CNT_W;

  logic             fire;
  logic             t_sop;
  logic             t_eop;
  logic [CNT_W-1:0] t_pos;
  logic [PW-1:0]    in_pl;
  logic [PW-1:0]    out_pl;

  assign fire = in_valid && in_ready;

  pld_len_tracker #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst_n(rst_n), .step(fire), .byte_in(in_data),
    .is_sop(t_sop), .is_eop(t_eop), .pos(t_pos)
  );

  assign in_pl = {in_page_end, t_sop, t_eop, t_pos, in_data};

  pld_out_slice #(.W(PW)) u_slice (
    .clk(clk), .rst_n(rst_n),
    .s_valid(in_valid), .s_ready(in_ready), .s_payload(in_pl),
    .m_valid(out_valid), .m_ready(out_ready), .m_payload(out_pl)
  );

  assign {out_page_end, out_sop, out_eop, out_pos, out_data} = out_pl;

  // checker state for ordering properties
  logic             last_eop_q;
  logic [CNT_W-1:0] last_pos_q;
  logic             seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_eop_q <= 1'b0;
      last_pos_q <= '0;
      seen_q     <= 1'b0;
    end else if (out_valid && out_ready) begin
      last_eop_q <= out_eop;
      last_pos_q <= out_pos;
      seen_q     <= 1'b1;
    end
  end

  // R3: packet start sits at position zero
  a_r3_sop_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> (out_pos == '0));

  // R6: the beat after an end beat opens a packet
  a_r6_sop_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen_q && last_eop_q) |-> out_sop);

  // R8: positions within a packet rise by one
  a_r8_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen_q && !out_sop) |-> (out_pos == last_pos_q + CNT_W'(1)));
endmodule

// File: tb/pkt_len_delim_tb.sv
module pkt_len_delim_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_page_end = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_page_end;
  logic        out_sop;
  logic        out_eop;
  logic [16:0] out_pos;

  always #10 clk = ~clk;

  pkt_len_delim u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_page_end(in_page_end), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_page_end(out_page_end),
    .out_sop(out_sop), .out_eop(out_eop), .out_pos(out_pos)
  );

  int n_checks = 0;
  int n_fail = 0;

  logic [7:0]  q_data [2048];
  logic        q_page [2048];
  logic        e_sop  [2048];
  logic        e_eop  [2048];
  int          e_pos  [2048];
  int          n_in;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_q();
    n_in = 0;
  endtask

  // length field MSB first, payload bytes follow; cap truncates the packet
  task automatic add_pkt(input int len, input int cap);
    int total = len + 2;
    if (cap < total) total = cap;
    for (int i = 0; i < total; i++) begin
      if (i == 0)      q_data[n_in] = 8'((len >> 8) & 255);
      else if (i == 1) q_data[n_in] = 8'(len & 255);
      else             q_data[n_in] = 8'((i * 7 + len) & 255);
      e_sop[n_in] = (i == 0);
      e_eop[n_in] = (i == len + 1);
      e_pos[n_in] = i;
      q_page[n_in] = 1'b0;
      n_in++;
    end
  endtask

  task automatic mark_pages(input int psz);
    for (int k = 0; k < n_in; k++) q_page[k] = ((k % psz) == psz - 1);
  endtask

  task automatic run(input bit stress, input string tag);
    int sent = 0, got = 0, cyc = 0;
    bit hold = 0;
    logic [7:0] h_data = '0;
    logic [16:0] h_pos = '0;
    logic h_flags = 1'b0;
    while (got < n_in && cyc < 20000) begin
      @(negedge clk);
      if (hold) begin
        check(out_valid === 1'b1 && out_data === h_data && out_pos === h_pos
              && out_eop === h_flags, "R2 held beat changed", int'(out_data), int'(h_data));
      end
      in_valid    = (sent < n_in) && (!stress || (cyc % 5) != 2);
      in_data     = q_data[sent < n_in ? sent : 0];
      in_page_end = q_page[sent < n_in ? sent : 0];
      out_ready   = !stress || (cyc % 3) != 1;
      #1;
      check(in_ready === (!out_valid || out_ready), "R2 in_ready rule", int'(in_ready),
            int'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        check(out_data === q_data[got], {tag, " R7 data"}, int'(out_data), int'(q_data[got]));
        check(out_page_end === q_page[got], {tag, " R7 page flag"}, int'(out_page_end), int'(q_page[got]));
        check(out_sop === e_sop[got], {tag, " R3/R6 sop"}, int'(out_sop), int'(e_sop[got]));
        check(out_eop === e_eop[got], {tag, " R4/R5 eop"}, int'(out_eop), int'(e_eop[got]));
        check(int'(out_pos) == e_pos[got], {tag, " R8 pos"}, int'(out_pos), e_pos[got]);
        got++;
      end
      if (in_valid && in_ready) sent++;
      hold    = out_valid && !out_ready;
      h_data  = out_data;
      h_pos   = out_pos;
      h_flags = out_eop;
      cyc++;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    check(got == n_in, {tag, " all beats delivered"}, got, n_in);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    check(in_ready === 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_single();
    clear_q(); add_pkt(4, 9999); mark_pages(4096);
    run(1'b0, "R4 single");
  endtask

  task automatic t_zero_and_one();
    clear_q(); add_pkt(0, 9999); add_pkt(1, 9999); add_pkt(0, 9999);
    mark_pages(4096);
    run(1'b0, "R5 R6 short");
  endtask

  task automatic t_pages();
    clear_q(); add_pkt(9, 9999); add_pkt(3, 9999); add_pkt(12, 9999); add_pkt(0, 9999);
    mark_pages(5);
    run(1'b0, "R7 paged");
  endtask

  task automatic t_long_stress();
    clear_q(); add_pkt(300, 9999); add_pkt(2, 9999);
    mark_pages(64);
    run(1'b1, "R2 R4 long");
  endtask

  task automatic t_mid_reset();
    clear_q(); add_pkt(10, 5); mark_pages(4096);
    run(1'b0, "R1 partial");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    clear_q(); add_pkt(2, 9999); mark_pages(4096);
    run(1'b0, "R1 restart");
  endtask

  initial begin
    t_reset_state();
    t_single();
    t_zero_and_one();
    t_pages();
    t_long_stress();
    t_mid_reset();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule